// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves a PLL to a new output rate when asked. A requester presents a target rate value and the reference rate together with a one-cycle request strobe. The block searches a small table of rates fixed at elaboration. Each table row holds a rate and the divider, multiplier and post-shift settings that produce it. The PLL output follows out = (in × M / N) >> OD. When a row matches, the block holds the PLL in reset and writes the three settings one at a time. It then releases reset and waits a bounded number of cycles for the PLL to report lock.

If lock does not arrive in time, the block reprograms the settings that were active before the request. It does this only once. The outcome is reported as a one-cycle completion pulse with a failure flag. A separate combinational port rounds an arbitrary rate up to a supported one, so that requesters can choose a legal rate before they ask.

Top module: `pll_reprog_seq`

## Requirements
- R1: An accepted request whose rate equals a table row (with nonzero rate and nonzero reference) leaves `pll_n`, `pll_m`, `pll_od` equal to that row's settings when `done` pulses with `fail` low.
- R2: A request with a zero rate, a zero reference rate, or a rate matching no row is rejected. `done` and `fail` are high in the cycle after acceptance, `pll_rst` stays low, and the settings do not change.
- R3: Programming follows a fixed order. `pll_rst` rises the cycle after acceptance. N changes one cycle later, M one cycle after N, and OD one cycle after M. `pll_rst` falls in the following cycle, before lock is sampled. The settings change only while `pll_rst` is high.
- R4: When `pll_lock` is seen high during the wait, `done` pulses in the next cycle and `fail` is low, unless a fallback has already happened.
- R5: If lock is not seen within `LOCK_TIMEOUT` wait cycles, the previously active settings are reprogrammed in the same order with a fresh reset pulse. The sequence then ends with `fail` high even if the fallback locks.
- R6: The fallback happens at most once. A second timeout ends the sequence with `done` and `fail` high, and no further reset pulse follows.
- R7: `busy` is high from the cycle after acceptance until `done` has pulsed. Requests presented while busy are ignored.
- R8: `done` is a single-cycle pulse for each accepted request.
- R9: `rnd_rate` is the first table rate (in ascending row order) that is at or above `rnd_in`. If no such rate exists, it is the rate in row 0.
- R10: After reset, `busy`, `done`, `fail` and `pll_rst` are low and the settings equal `INIT_N`, `INIT_M`, `INIT_OD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_rate | input | RATE_W | Requested output rate |
| ref_rate | input | RATE_W | Reference rate feeding the PLL |
| pll_lock | input | 1 | Lock indication from the PLL |
| rnd_in | input | RATE_W | Rate to round to a supported value |
| pll_n | output | NW | Input divider setting |
| pll_m | output | MW | Feedback multiplier setting |
| pll_od | output | OW | Output shift setting |
| pll_rst | output | 1 | PLL reset, high while settings are written |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | Valid with `done`: request rejected or lock fallback taken |
| rnd_rate | output | RATE_W | Rounded supported rate for `rnd_in` |

## Verification
The assertions take for granted a rate table held in strictly ascending order, which is enforced at elaboration. They also assume that `req_valid` and the rate inputs are defined once reset is released. They place no rule on `pll_lock`; the checks on ordering and single fallback hold whatever the PLL does. The stimulus drives every input on the falling edge. It models lock as present only while reset is low and the multiplier is not one chosen unreachable value. This lets both a recoverable timeout and a double timeout (with lock globally withheld) be produced in a handful of cycles, using a short timeout parameter.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WN,
      S_WM,
      S_WOD,
      S_REL,
      S_WAIT,
      S_FIN
   } seq_state_t;
endpackage

// File: rtl/pll_rate_lookup.sv
module pll_rate_lookup #(
   parameter int RATE_W = 16,
   parameter int NW     = 9,
   parameter int MW     = 9,
   parameter int OW     = 2,
   parameter int DEPTH  = 4,
   parameter logic [DEPTH*RATE_W-1:0] TBL_RATE = '0,
   parameter logic [DEPTH*NW-1:0]     TBL_N    = '0,
   parameter logic [DEPTH*MW-1:0]     TBL_M    = '0,
   parameter logic [DEPTH*OW-1:0]     TBL_OD   = '0
) (
   input  logic [RATE_W-1:0] rate,
   input  logic [RATE_W-1:0] ref_rate,
   output logic              hit,
   output logic [NW-1:0]     n,
   output logic [MW-1:0]     m,
   output logic [OW-1:0]     od
);
   logic [DEPTH-1:0] match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = (rate == TBL_RATE[g*RATE_W +: RATE_W]);
   end

   always_comb begin
      n  = '0;
      m  = '0;
      od = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            n  = TBL_N[i*NW +: NW];
            m  = TBL_M[i*MW +: MW];
            od = TBL_OD[i*OW +: OW];
         end
      end
      hit = (|match) && (rate != '0) && (ref_rate != '0);
   end
endmodule

// File: rtl/pll_rate_round.sv
module pll_rate_round #(
   parameter int RATE_W = 16,
   parameter int DEPTH  = 4,
   parameter logic [DEPTH*RATE_W-1:0] TBL_RATE = '0
) (
   input  logic [RATE_W-1:0] q,
   output logic              found,
   output logic [RATE_W-1:0] rate
);
   logic [DEPTH-1:0] ge;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ge
      assign ge[g] = (TBL_RATE[g*RATE_W +: RATE_W] >= q);
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_order
      if (TBL_RATE[g*RATE_W +: RATE_W] <= TBL_RATE[(g-1)*RATE_W +: RATE_W]) begin : g_bad
         $error("rate table rows must be strictly ascending");
      end
   end

   always_comb begin
      rate = TBL_RATE[0 +: RATE_W];
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (ge[i]) rate = TBL_RATE[i*RATE_W +: RATE_W];
      end
      found = |ge;
   end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LIMIT = 24_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run)         cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run && !expired |=> cnt != '0 || !run); // R5
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int RATE_W       = 16,
   parameter int NW           = 9,
   parameter int MW           = 9,
   parameter int OW           = 2,
   parameter int DEPTH        = 4,
   parameter int LOCK_TIMEOUT = 24_000_000,
   parameter logic [DEPTH*RATE_W-1:0] TBL_RATE = {16'd600, 16'd504, 16'd408, 16'd312},
   parameter logic [DEPTH*NW-1:0]     TBL_N    = {9'd2,  9'd1,  9'd1,  9'd2},
   parameter logic [DEPTH*MW-1:0]     TBL_M    = {9'd50, 9'd42, 9'd17, 9'd26},
   parameter logic [DEPTH*OW-1:0]     TBL_OD   = {2'd0,  2'd1,  2'd0,  2'd0},
   parameter logic [NW-1:0] INIT_N  = 9'd1,
   parameter logic [MW-1:0] INIT_M  = 9'd17,
   parameter logic [OW-1:0] INIT_OD = 2'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [RATE_W-1:0] req_rate,
   input  logic [RATE_W-1:0] ref_rate,
   input  logic              pll_lock,
   input  logic [RATE_W-1:0] rnd_in,
   output logic [NW-1:0]     pll_n,
   output logic [MW-1:0]     pll_m,
   output logic [OW-1:0]     pll_od,
   output logic              pll_rst,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [RATE_W-1:0] rnd_rate
);
   if (LOCK_TIMEOUT < 2) begin : g_bad_tmo
      $error("LOCK_TIMEOUT must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   localparam int SETW = NW + MW + OW;

   seq_state_t      st;
   logic            lk_hit;
   logic [NW-1:0]   lk_n;
   logic [MW-1:0]   lk_m;
   logic [OW-1:0]   lk_od;
   logic [SETW-1:0] tgt, prv, cur;
   logic            fb_q, fail_q, rst_q, tmo, rnd_found;

   pll_rate_lookup #(
      .RATE_W(RATE_W), .NW(NW), .MW(MW), .OW(OW), .DEPTH(DEPTH),
      .TBL_RATE(TBL_RATE), .TBL_N(TBL_N), .TBL_M(TBL_M), .TBL_OD(TBL_OD)
   ) u_lookup (
      .rate(req_rate), .ref_rate(ref_rate),
      .hit(lk_hit), .n(lk_n), .m(lk_m), .od(lk_od)
   );

   pll_rate_round #(
      .RATE_W(RATE_W), .DEPTH(DEPTH), .TBL_RATE(TBL_RATE)
   ) u_round (
      .q(rnd_in), .found(rnd_found), .rate(rnd_rate)
   );

   pll_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st == S_WAIT), .expired(tmo)
   );

   assign cur = {pll_n, pll_m, pll_od};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         pll_n  <= INIT_N;
         pll_m  <= INIT_M;
         pll_od <= INIT_OD;
         tgt    <= {INIT_N, INIT_M, INIT_OD};
         prv    <= {INIT_N, INIT_M, INIT_OD};
         rst_q  <= 1'b0;
         fb_q   <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               if (lk_hit) begin
                  tgt   <= {lk_n, lk_m, lk_od};
                  prv   <= cur;
                  rst_q <= 1'b1;
                  fb_q  <= 1'b0;
                  st    <= S_WN;
               end else begin
                  fail_q <= 1'b1;
                  st     <= S_FIN;
               end
            end
            S_WN:  begin pll_n  <= tgt[SETW-1 -: NW]; st <= S_WM;  end
            S_WM:  begin pll_m  <= tgt[OW +: MW];     st <= S_WOD; end
            S_WOD: begin pll_od <= tgt[OW-1:0];       st <= S_REL; end
            S_REL: begin rst_q  <= 1'b0;              st <= S_WAIT; end
            S_WAIT: begin
               if (pll_lock) begin
                  fail_q <= fb_q;
                  st     <= S_FIN;
               end else if (tmo) begin
                  if (fb_q) begin
                     fail_q <= 1'b1;
                     st     <= S_FIN;
                  end else begin
                     fb_q  <= 1'b1;
                     tgt   <= prv;
                     rst_q <= 1'b1;
                     st    <= S_WN;
                  end
               end
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign pll_rst = rst_q;
   assign busy    = (st != S_IDLE);
   assign done    = (st == S_FIN);
   assign fail    = done && fail_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_WRITE_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur) |-> pll_rst); // R3
   AST_WAIT_RST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT) |-> !pll_rst); // R3
   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && req_valid && !lk_hit) |=> done && fail && !pll_rst && $stable(cur)); // R2
   AST_SINGLE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT && tmo && !pll_lock && fb_q) |=> done && fail); // R6
   AST_LOCK_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT && pll_lock && !fb_q) |=> done && !fail); // R4
   AST_ROUND_GE: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_found |-> rnd_rate >= rnd_in); // R9
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
   localparam int TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_rate = '0;
   logic [15:0] ref_rate = 16'd24;
   logic [15:0] rnd_in = '0;
   logic        lock_en = 1'b1;
   logic        pll_lock;
   logic [8:0]  pll_n, pll_m;
   logic [1:0]  pll_od;
   logic        pll_rst, busy, done, fail;
   logic [15:0] rnd_rate;

   int n_run = 0;
   int n_fail = 0;
   int rises = 0;
   logic rst_d = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pll_reprog_seq #(.LOCK_TIMEOUT(TMO)) u_pll_reprog_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate(req_rate),
      .ref_rate(ref_rate), .pll_lock(pll_lock), .rnd_in(rnd_in),
      .pll_n(pll_n), .pll_m(pll_m), .pll_od(pll_od), .pll_rst(pll_rst),
      .busy(busy), .done(done), .fail(fail), .rnd_rate(rnd_rate)
   );

   // behavioural PLL: locks while out of reset, except for multiplier 50
   assign pll_lock = !pll_rst && lock_en && (pll_m != 9'd50);

   always @(posedge clk) begin
      if (pll_rst && !rst_d) rises <= rises + 1;
      rst_d <= pll_rst;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int setv(input logic [8:0] n, input logic [8:0] m, input logic [1:0] od);
      return {n, m, od};
   endfunction

   task automatic request(input logic [15:0] rate, input logic [15:0] rf);
      @(negedge clk);
      req_valid = 1'b1; req_rate = rate; ref_rate = rf;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output logic f);
      for (int k = 0; k < 300; k++) begin
         if (done) break;
         @(negedge clk);
      end
      chk(done, "R8 done seen", done, 1);
      f = fail;
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
   endtask

   // {rate, ref, fail, n, m, od}
   localparam int VW = 16 + 16 + 1 + 9 + 9 + 2;
   localparam logic [VW-1:0] VEC [7] = '{
      {16'd312, 16'd24, 1'b0, 9'd2, 9'd26, 2'd0},
      {16'd504, 16'd24, 1'b0, 9'd1, 9'd42, 2'd1},
      {16'd0,   16'd24, 1'b1, 9'd1, 9'd42, 2'd1},
      {16'd505, 16'd24, 1'b1, 9'd1, 9'd42, 2'd1},
      {16'd408, 16'd0,  1'b1, 9'd1, 9'd42, 2'd1},
      {16'd408, 16'd24, 1'b0, 9'd1, 9'd17, 2'd0},
      {16'd312, 16'd24, 1'b0, 9'd2, 9'd26, 2'd0}
   };

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic f;
      int r0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!busy && !done && !fail && !pll_rst, "R10 status after reset", {busy, done, fail, pll_rst}, 0);
      chk(setv(pll_n, pll_m, pll_od) == setv(1, 17, 0), "R10 initial settings", setv(pll_n, pll_m, pll_od), setv(1, 17, 0));
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk: R1 matches, R2 rejects, R4 lock path
      for (int v = 0; v < 7; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         r0 = rises;
         request(e[VW-1 -: 16], e[VW-17 -: 16]);
         if (e[20]) chk(done && fail && !pll_rst, "R2 reject next cycle", {done, fail, pll_rst}, 3'b110);
         wait_done(f);
         chk(f == e[20], e[20] ? "R2 fail flag" : "R4 fail flag low", f, e[20]);
         chk(setv(pll_n, pll_m, pll_od) == int'(e[19:0]), e[20] ? "R2 settings kept" : "R1 settings programmed",
             setv(pll_n, pll_m, pll_od), int'(e[19:0]));
         if (e[20]) chk(rises == r0, "R2 no reset pulse", rises - r0, 0);
      end

      // R3 order 312 -> 504, with an ignored request while busy (R7)
      @(negedge clk);
      req_valid = 1'b1; req_rate = 16'd504; ref_rate = 16'd24;
      @(negedge clk); req_valid = 1'b0;
      chk(pll_rst && busy && setv(pll_n, pll_m, pll_od) == setv(2, 26, 0), "R3 reset first", setv(pll_n, pll_m, pll_od), setv(2, 26, 0));
      @(negedge clk);
      chk(pll_rst && setv(pll_n, pll_m, pll_od) == setv(1, 26, 0), "R3 N second", setv(pll_n, pll_m, pll_od), setv(1, 26, 0));
      req_valid = 1'b1; req_rate = 16'd600;
      @(negedge clk); req_valid = 1'b0;
      chk(pll_rst && setv(pll_n, pll_m, pll_od) == setv(1, 42, 0), "R3 M third", setv(pll_n, pll_m, pll_od), setv(1, 42, 0));
      @(negedge clk);
      chk(pll_rst && setv(pll_n, pll_m, pll_od) == setv(1, 42, 1), "R3 OD fourth", setv(pll_n, pll_m, pll_od), setv(1, 42, 1));
      @(negedge clk);
      chk(!pll_rst && busy && !done, "R3 reset released before wait", {pll_rst, busy, done}, 3'b010);
      @(negedge clk);
      chk(done && !fail, "R4 done after lock", {done, fail}, 2'b10);
      @(negedge clk);
      chk(!done && !busy, "R8 single done", {done, busy}, 0);
      repeat (8) @(negedge clk);
      chk(!busy && setv(pll_n, pll_m, pll_od) == setv(1, 42, 1), "R7 busy request ignored", setv(pll_n, pll_m, pll_od), setv(1, 42, 1));

      // R5 timeout on 600, fallback to 504 locks, failure reported
      r0 = rises;
      request(16'd600, 16'd24);
      wait_done(f);
      chk(f == 1'b1, "R5 fail after fallback", f, 1);
      chk(setv(pll_n, pll_m, pll_od) == setv(1, 42, 1), "R5 previous settings restored", setv(pll_n, pll_m, pll_od), setv(1, 42, 1));
      chk(rises - r0 == 2, "R5 second reset pulse", rises - r0, 2);

      // R6 double timeout: lock withheld
      lock_en = 1'b0;
      r0 = rises;
      request(16'd312, 16'd24);
      wait_done(f);
      chk(f == 1'b1, "R6 fail after second timeout", f, 1);
      chk(setv(pll_n, pll_m, pll_od) == setv(1, 42, 1), "R6 left at previous settings", setv(pll_n, pll_m, pll_od), setv(1, 42, 1));
      repeat (40) @(negedge clk);
      chk(rises - r0 == 2 && !busy, "R6 no third attempt", rises - r0, 2);
      lock_en = 1'b1;

      // R9 rounding
      rnd_in = 16'd1;   #1; chk(rnd_rate == 16'd312, "R9 below table", rnd_rate, 312);
      rnd_in = 16'd312; #1; chk(rnd_rate == 16'd312, "R9 exact row", rnd_rate, 312);
      rnd_in = 16'd313; #1; chk(rnd_rate == 16'd408, "R9 round up", rnd_rate, 408);
      rnd_in = 16'd600; #1; chk(rnd_rate == 16'd600, "R9 top row", rnd_rate, 600);
      rnd_in = 16'd601; #1; chk(rnd_rate == 16'd312, "R9 above table", rnd_rate, 312);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule